// File: doc/BRIEF.md
# Clock power and watchdog controller

This unit sits beside a small processor core and decides, cycle by cycle, whether the crystal oscillator runs, whether the instruction clock reaches the core, and which clock-divider setting the core clock uses. It also contains a watchdog that issues a reset pulse when software stops servicing it. The oscillator and the core clock are modelled as enable signals. The clock tree and pad logic downstream act on them.

Software writes one control word, given here as separate field inputs qualified by a single write strobe. The word carries a sleep request (deep or light), the double-rate clock choice and the watchdog enable. A separate strobe restarts the watchdog. Any interrupt line that is both pending and enabled brings the core out of either sleep state. Leaving deep sleep goes through a fixed oscillator-settle wait before the core clock is enabled again. A deep-sleep request made while the double-rate clock is selected is refused, and an error flag records the refusal.

Top module: `cpw_ctrl`

## Requirements
- R1: After reset, osc_run=1, cpu_clk_en=1, clk_div_sel=0, wdt_rst=0 and pd_err=0, and the watchdog is disabled.
- R2: An accepted control write with ctl_pd=1 makes osc_run and cpu_clk_en both 0 from the next cycle on. The write is accepted when neither the stored fast bit nor ctl_fast in that write is 1.
- R3: A control write with ctl_idle=1 and ctl_pd=0 makes cpu_clk_en 0 from the next cycle on, while osc_run stays 1.
- R4: Light or deep sleep ends only when some bit i has irq_pend[i]=1 and irq_en[i]=1. A pending bit whose enable is 0 leaves both clock outputs unchanged. Leaving light sleep sets cpu_clk_en to 1 on the cycle after the wake condition.
- R5: On leaving deep sleep, osc_run becomes 1 on the cycle after the wake condition. cpu_clk_en becomes 1 exactly SETTLE_CYC cycles after that.
- R6: clk_div_sel holds the fast bit from the last accepted control write (1 = double rate).
- R7: A control write with ctl_pd=1 is refused when the stored fast bit or ctl_fast is 1. The clocks stay running and pd_err becomes 1. The fast and watchdog-enable fields of that write are still stored. The next control write that is not refused sets pd_err back to 0.
- R8: While enabled, the watchdog counts every cycle in which the oscillator runs. After (CLK_HZ*64)/100 counted cycles, which is 0.64 s of input clock, it drives wdt_rst high for one cycle and starts again from zero. Disabling the watchdog clears the count and keeps wdt_rst at 0.
- R9: A wdt_kick strobe resets the watchdog count to zero, so the next pulse comes a full timeout after the kick.
- R10: The watchdog count is frozen while the oscillator is stopped. The cycles spent in deep sleep do not count toward the timeout.
- R11: Control writes made while the core clock is gated (light sleep, deep sleep or settle) are ignored. They change no stored field and start no mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_pd | input | 1 | Deep-sleep request field |
| ctl_idle | input | 1 | Light-sleep request field |
| ctl_fast | input | 1 | Double-rate core clock field |
| ctl_wdt_en | input | 1 | Watchdog enable field |
| wdt_kick | input | 1 | Watchdog restart strobe |
| irq_pend | input | N_IRQ | Pending interrupt requests |
| irq_en | input | N_IRQ | Interrupt enable bits |
| osc_run | output | 1 | Oscillator run enable |
| cpu_clk_en | output | 1 | Core clock gate enable |
| clk_div_sel | output | 1 | Divider select, 1 = double rate |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |
| pd_err | output | 1 | Refused deep-sleep request flag |

## Verification
The bench counts the exact settle delay after deep-sleep wake. A design that is off by one in the settle counter would re-enable the core clock one cycle early or late. Masked interrupts are raised during both sleep states, which catches a wake term that ignores the enable bits. Deep-sleep requests are refused both when the fast bit is already stored and when it is written in the same word, and the flag must clear afterwards. The watchdog is timed from enable, from a kick, after a disable/enable cycle and across a deep-sleep stretch. A counter that keeps running with the oscillator stopped, or that survives a disable, fires early. Writes made during light sleep must leave the divider select and the watchdog untouched.

// File: rtl/cpw_pkg.sv
package cpw_pkg;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_IDLE   = 2'd1,
    MODE_PDOWN  = 2'd2,
    MODE_SETTLE = 2'd3
  } cpw_mode_e;

endpackage

// File: rtl/cpw_rst_sync.sv
module cpw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  // assert immediately, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/cpw_wake.sv
module cpw_wake #(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             wake
);

  logic [N_IRQ-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < N_IRQ; gi++) begin : g_line
      assign hit[gi] = irq_pend[gi] & irq_en[gi];
    end
  endgenerate

  assign wake = |hit;

endmodule

// File: rtl/cpw_mode_fsm.sv
module cpw_mode_fsm
  import cpw_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_pd,
  input  logic ctl_idle,
  input  logic ctl_fast,
  input  logic ctl_wdt_en,
  input  logic wake,
  output logic osc_run,
  output logic cpu_clk_en,
  output logic fast_en,
  output logic wdt_en,
  output logic pd_err
);

  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [SW-1:0] STL_LAST = SW'(SETTLE_CYC - 1);

  cpw_mode_e     state_q, state_d;
  logic [SW-1:0] stl_q, stl_d;
  logic          fast_q, fast_d;
  logic          wen_q, wen_d;
  logic          err_q, err_d;

  logic wr_ok;
  logic pd_blocked;

  assign wr_ok      = ctl_wr && (state_q == MODE_RUN);
  assign pd_blocked = ctl_pd && (fast_q || ctl_fast);

  always_comb begin
    state_d = state_q;
    stl_d   = stl_q;
    fast_d  = fast_q;
    wen_d   = wen_q;
    err_d   = err_q;
    unique case (state_q)
      MODE_RUN: begin
        if (wr_ok) begin
          fast_d = ctl_fast;
          wen_d  = ctl_wdt_en;
          err_d  = pd_blocked;
          if (ctl_pd && !pd_blocked) begin
            state_d = MODE_PDOWN;
          end else if (!ctl_pd && ctl_idle) begin
            state_d = MODE_IDLE;
          end
        end
      end
      MODE_IDLE: begin
        if (wake) state_d = MODE_RUN;
      end
      MODE_PDOWN: begin
        if (wake) begin
          state_d = MODE_SETTLE;
          stl_d   = '0;
        end
      end
      MODE_SETTLE: begin
        if (stl_q == STL_LAST) begin
          state_d = MODE_RUN;
        end else begin
          stl_d = stl_q + 1'b1;
        end
      end
      default: state_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MODE_RUN;
      stl_q   <= '0;
      fast_q  <= 1'b0;
      wen_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stl_q   <= stl_d;
      fast_q  <= fast_d;
      wen_q   <= wen_d;
      err_q   <= err_d;
    end
  end

  assign osc_run    = (state_q != MODE_PDOWN);
  assign cpu_clk_en = (state_q == MODE_RUN);
  assign fast_en    = fast_q;
  assign wdt_en     = wen_q;
  assign pd_err     = err_q;

  assert_pd_stops_clocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && ctl_pd && !fast_q && !ctl_fast) |=> (!osc_run && !cpu_clk_en));

  assert_idle_keeps_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && ctl_idle && !ctl_pd) |=> (osc_run && !cpu_clk_en));

  assert_idle_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_IDLE && wake) |=> cpu_clk_en);

  assert_pd_stays_without_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_PDOWN && !wake) |=> !osc_run);

  assert_pd_wake_settles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_PDOWN && wake) |=> (osc_run && !cpu_clk_en));

  assert_fast_blocks_pd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && pd_blocked) |=> (osc_run && cpu_clk_en && pd_err));

  assert_gated_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !cpu_clk_en) |=> ($stable(fast_en) && $stable(wdt_en) && $stable(pd_err)));

endmodule

// File: rtl/cpw_wdt.sv
module cpw_wdt #(
  parameter int unsigned CLK_HZ = 6_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_on,
  input  logic osc_run,
  input  logic kick,
  output logic wdt_rst
);

  localparam longint unsigned TICKS = (longint'(CLK_HZ) * 64) / 100;
  localparam int W = $clog2(TICKS);
  localparam logic [W-1:0] CNT_LAST = W'(TICKS - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         rst_q, rst_d;
  logic         cnt_en;

  assign cnt_en = wdt_on && osc_run;

  always_comb begin
    cnt_d = cnt_q;
    rst_d = 1'b0;
    if (kick || !wdt_on) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      if (cnt_q == CNT_LAST) begin
        cnt_d = '0;
        rst_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= rst_d;
    end
  end

  assign wdt_rst = rst_q;

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  assert_off_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_on |=> !wdt_rst);

  assert_kick_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !wdt_rst);

  assert_frozen_when_osc_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_on && !osc_run && !kick) |=> ($stable(cnt_q) && !wdt_rst));

endmodule

// File: rtl/cpw_ctrl.sv
module cpw_ctrl #(
  parameter int          N_IRQ      = 4,
  parameter int unsigned CLK_HZ     = 6_000_000,
  parameter int          SETTLE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_pd,
  input  logic             ctl_idle,
  input  logic             ctl_fast,
  input  logic             ctl_wdt_en,
  input  logic             wdt_kick,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             osc_run,
  output logic             cpu_clk_en,
  output logic             clk_div_sel,
  output logic             wdt_rst,
  output logic             pd_err
);

  logic rst_sync_n;
  logic wake;
  logic wdt_en;
  logic fast_en;

  cpw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cpw_wake #(.N_IRQ(N_IRQ)) u_wake (
    .irq_pend (irq_pend),
    .irq_en   (irq_en),
    .wake     (wake)
  );

  cpw_mode_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ctl_wr     (ctl_wr),
    .ctl_pd     (ctl_pd),
    .ctl_idle   (ctl_idle),
    .ctl_fast   (ctl_fast),
    .ctl_wdt_en (ctl_wdt_en),
    .wake       (wake),
    .osc_run    (osc_run),
    .cpu_clk_en (cpu_clk_en),
    .fast_en    (fast_en),
    .wdt_en     (wdt_en),
    .pd_err     (pd_err)
  );

  cpw_wdt #(.CLK_HZ(CLK_HZ)) u_wdt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wdt_on  (wdt_en),
    .osc_run (osc_run),
    .kick    (wdt_kick),
    .wdt_rst (wdt_rst)
  );

  assign clk_div_sel = fast_en;

  assert_div_follows_write_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_wr && cpu_clk_en) |=> (clk_div_sel == $past(ctl_fast)));

endmodule

// File: tb/tb_cpw_ctrl.sv
module tb_cpw_ctrl;

  localparam int NI = 4;
  localparam int HZ = 1000;
  localparam int SC = 8;
  localparam int T  = (HZ * 64) / 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0, ctl_pd = 1'b0, ctl_idle = 1'b0, ctl_fast = 1'b0, ctl_wdt_en = 1'b0;
  logic wdt_kick = 1'b0;
  logic [NI-1:0] irq_pend = '0;
  logic [NI-1:0] irq_en = 4'b1110;
  logic osc_run, cpu_clk_en, clk_div_sel, wdt_rst, pd_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  cpw_ctrl #(.N_IRQ(NI), .CLK_HZ(HZ), .SETTLE_CYC(SC)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_pd(ctl_pd), .ctl_idle(ctl_idle),
    .ctl_fast(ctl_fast), .ctl_wdt_en(ctl_wdt_en), .wdt_kick(wdt_kick),
    .irq_pend(irq_pend), .irq_en(irq_en), .osc_run(osc_run), .cpu_clk_en(cpu_clk_en),
    .clk_div_sel(clk_div_sel), .wdt_rst(wdt_rst), .pd_err(pd_err)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ctl_write(input bit pd, input bit idle, input bit fast, input bit wen);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_pd = pd; ctl_idle = idle; ctl_fast = fast; ctl_wdt_en = wen;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_pd = 1'b0; ctl_idle = 1'b0; ctl_fast = 1'b0; ctl_wdt_en = 1'b0;
  endtask

  task automatic pulse_irq(input int idx);
    @(negedge clk);
    irq_pend[idx] = 1'b1;
    @(negedge clk);
    irq_pend[idx] = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk);
    wdt_kick = 1'b1;
    @(negedge clk);
    wdt_kick = 1'b0;
  endtask

  task automatic wait_pulse(input int limit, output int n);
    n = 0;
    while (wdt_rst !== 1'b1 && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R1", "osc_run", osc_run, 1);
    chk("R1", "cpu_clk_en", cpu_clk_en, 1);
    chk("R1", "clk_div_sel", clk_div_sel, 0);
    chk("R1", "wdt_rst", wdt_rst, 0);
    chk("R1", "pd_err", pd_err, 0);
  endtask

  task automatic t_idle();
    ctl_write(0, 1, 0, 0);
    chk("R3", "cpu_clk_en in idle", cpu_clk_en, 0);
    chk("R3", "osc_run in idle", osc_run, 1);
    pulse_irq(0);
    chk("R4", "masked irq leaves idle", cpu_clk_en, 0);
    pulse_irq(1);
    chk("R4", "enabled irq wakes idle", cpu_clk_en, 1);
  endtask

  task automatic t_ignore_in_idle();
    int n;
    ctl_write(0, 1, 0, 0);
    ctl_write(0, 0, 1, 1);
    chk("R11", "fast ignored in idle", clk_div_sel, 0);
    chk("R11", "still idle", cpu_clk_en, 0);
    pulse_irq(2);
    chk("R4", "wake after ignored write", cpu_clk_en, 1);
    chk("R11", "fast still clear", clk_div_sel, 0);
    wait_pulse(T + 20, n);
    chk("R11", "watchdog not enabled by ignored write", n, T + 20);
  endtask

  task automatic t_pdown();
    ctl_write(1, 0, 0, 0);
    chk("R2", "osc_run in pd", osc_run, 0);
    chk("R2", "cpu_clk_en in pd", cpu_clk_en, 0);
    pulse_irq(0);
    chk("R4", "masked irq leaves pd", osc_run, 0);
    pulse_irq(3);
    chk("R5", "osc back after wake", osc_run, 1);
    chk("R5", "cpu gated during settle", cpu_clk_en, 0);
    repeat (SC - 1) @(negedge clk);
    chk("R5", "cpu gated one before settle end", cpu_clk_en, 0);
    @(negedge clk);
    chk("R5", "cpu back after settle", cpu_clk_en, 1);
  endtask

  task automatic t_fast();
    ctl_write(0, 0, 1, 0);
    chk("R6", "double rate selected", clk_div_sel, 1);
    ctl_write(1, 0, 1, 0);
    chk("R7", "pd refused with fast, osc", osc_run, 1);
    chk("R7", "pd refused with fast, cpu", cpu_clk_en, 1);
    chk("R7", "error flag set", pd_err, 1);
    ctl_write(1, 0, 0, 0);
    chk("R7", "pd refused while stored fast", osc_run, 1);
    chk("R7", "error flag still set", pd_err, 1);
    chk("R6", "fast field stored on refused write", clk_div_sel, 0);
    ctl_write(0, 0, 0, 0);
    chk("R7", "error flag cleared", pd_err, 0);
    ctl_write(1, 0, 0, 0);
    chk("R2", "pd accepted after fast cleared", osc_run, 0);
    pulse_irq(3);
    repeat (SC) @(negedge clk);
    chk("R5", "running again", cpu_clk_en, 1);
  endtask

  task automatic t_wdt();
    int n;
    ctl_write(0, 0, 0, 1);
    wait_pulse(2 * T, n);
    chk("R8", "timeout cycles", n, T);
    @(negedge clk);
    chk("R8", "pulse one cycle", wdt_rst, 0);
    ctl_write(0, 0, 0, 0);
    wait_pulse(T + 20, n);
    chk("R8", "no pulse when disabled", n, T + 20);
    ctl_write(0, 0, 0, 1);
    repeat (300) @(negedge clk);
    ctl_write(0, 0, 0, 0);
    ctl_write(0, 0, 0, 1);
    wait_pulse(2 * T, n);
    chk("R8", "disable clears count", n, T);
    ctl_write(0, 0, 0, 0);
  endtask

  task automatic t_kick();
    int n;
    ctl_write(0, 0, 0, 1);
    repeat (400) @(negedge clk);
    kick();
    wait_pulse(2 * T, n);
    chk("R9", "full timeout after kick", n, T);
    ctl_write(0, 0, 0, 0);
  endtask

  task automatic t_freeze();
    int counted;
    int c;
    counted = 0;
    c = 0;
    ctl_write(0, 0, 0, 1);
    while (wdt_rst !== 1'b1 && c < 4000) begin
      if (c == 100) begin
        ctl_wr = 1'b1; ctl_pd = 1'b1; ctl_wdt_en = 1'b1;
      end
      if (c == 101) begin
        ctl_wr = 1'b0; ctl_pd = 1'b0; ctl_wdt_en = 1'b0;
      end
      if (c == 700) irq_pend[3] = 1'b1;
      if (c == 701) irq_pend[3] = 1'b0;
      if (osc_run === 1'b1) counted++;
      @(negedge clk);
      c++;
    end
    chk("R10", "counted cycles at pulse", counted, T);
    chk("R10", "pulse delayed by pd stretch", (c > T + 500) ? 1 : 0, 1);
    ctl_write(0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_ignore_in_idle();
    t_pdown();
    t_fast();
    t_wdt();
    t_kick();
    t_freeze();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule